// File: doc/BRIEF.md
# Signalling Byte Assembler for Framed Serial Links

This block sits beside the frame timing of a time-division serial link. Each frame, it exchanges a small number of low-rate signalling bits with the link. On the receive side, it gathers the bits arriving over several consecutive frames into one byte for a host. On the transmit side, it takes a byte written by the host and hands it out a slice per frame.

The block has two rates:
- **High rate:** each frame carries a two-bit pair, and four frames make one byte.
- **Low rate:** each frame carries one bit, and eight frames make one byte.

A host read of the receive byte or a host write of the transmit byte realigns the frame count. This lets the host keep its own byte boundaries in step with the link.

The block sees one `frm_pulse` strobe per frame. It samples the incoming pair on that cycle and updates the outgoing pair at the same clock edge. Bit-level timing of the serial link is handled elsewhere.

Top module: `dch_assembler`

## Requirements
- R1: While `rst` is high and after it is released, `rx_byte` reads 8'hFF and `tx_pair` reads 2'b11 until the first frame pulse changes them.
- R2: In high rate (`rate_low`=0), four frame pulses form one byte. The pair taken at the first pulse lands in bits 7:6, the second in 5:4, the third in 3:2 and the fourth in 1:0. `rx_pair[1]` goes to the higher bit of each pair. `rx_byte` shows the new byte from the clock edge of the fourth pulse onward.
- R3: In low rate (`rate_low`=1), only `rx_pair[1]` is used. Eight frame pulses form one byte, with the first bit in bit 7 and the last bit in bit 0.
- R4: `rx_byte` changes only at the edge of the pulse that completes a byte, so a partly gathered byte is never visible.
- R5: In high rate, the frame pulse at slot k (k = 0..3) loads `tx_pair` with transmit byte bits [7-2k : 6-2k], the higher bit on `tx_pair[1]`.
- R6: In low rate, the frame pulse at slot k (k = 0..7) loads `tx_pair[1]` with transmit byte bit 7-k and drives `tx_pair[0]` to 1.
- R7: When no new transmit byte is written, every later cycle sends the last written byte again. The reset value is 8'hFF.
- R8: A cycle with `rd_strobe` or `wr_strobe` high restarts the frame count and discards any partly gathered receive bits. A frame pulse in that same cycle is counted as slot 0 of the new cycle. A byte written in that cycle is used for that slot.
- R9: If the rate changes while the slot count is at or beyond the last slot of the new rate, the next frame pulse is treated as the last slot: it completes the byte and wraps the count to 0.
- R10: `tx_pair` changes only at the edge of a frame pulse. A host write alone leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_pulse | input | 1 | One-cycle strobe, once per frame |
| rate_low | input | 1 | 1 = one bit per frame, 0 = two bits per frame |
| rx_pair | input | 2 | Signalling bits received in this frame, valid with `frm_pulse` |
| rd_strobe | input | 1 | Host read of the receive byte |
| wr_strobe | input | 1 | Host write of the transmit byte |
| wr_byte | input | 8 | Transmit byte, valid with `wr_strobe` |
| tx_pair | output | 2 | Signalling bits to send in the current frame |
| rx_byte | output | 8 | Last completed receive byte |

## Verification
The bench targets five corner cases:
- **Pair ordering.** A design that reverses the age order or swaps the two bits of a pair gives a byte such as 8'h36 where 8'h9C is due.
- **Host access on a pulse cycle.** If the access loses to the pulse, the count is off by one slot and every later byte is shifted.
- **Host write on a pulse cycle.** A write arriving together with a pulse must show the new byte in the same frame; a design that takes the old byte shows a stale slice.
- **Rate change beyond the last slot.** Switching to high rate while the count is past slot 3 must wrap the count. A design that does not wrap keeps counting and stops completing bytes.
- **Random runs.** Long random runs with host accesses at arbitrary points catch partial bytes showing up on `rx_byte` and `tx_pair` moving between frames.

// File: rtl/dch_pkg.sv
package dch_pkg;

    parameter int unsigned BYTE_BITS = 8;
    localparam int unsigned SLOT_W   = $clog2(BYTE_BITS);
    localparam int unsigned PAIR_SLOTS = BYTE_BITS / 2;

    typedef enum logic {
        RATE_PAIR   = 1'b0,
        RATE_SINGLE = 1'b1
    } rate_e;

    // What happens in the current cycle, as seen by both data paths.
    typedef struct packed {
        logic              go;       // a frame is processed now
        logic              restart;  // host access realigns the cycle
        logic              last;     // this frame completes a byte
        logic [SLOT_W-1:0] slot;     // slot index used for this frame
    } frame_ev_t;

    function automatic logic [SLOT_W-1:0] last_slot(input rate_e r);
        return (r == RATE_SINGLE) ? SLOT_W'(BYTE_BITS - 1) : SLOT_W'(PAIR_SLOTS - 1);
    endfunction

endpackage

// File: rtl/dch_slot_ctr.sv
module dch_slot_ctr
    import dch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_pulse,
    input  logic              host_acc,
    input  rate_e             rate,
    output frame_ev_t         ev,
    output logic [SLOT_W-1:0] slot_q
);

    logic [SLOT_W-1:0] cur;
    logic [SLOT_W-1:0] lim;
    logic              at_end;

    always_comb begin
        cur    = host_acc ? '0 : slot_q;
        lim    = last_slot(rate);
        at_end = (cur >= lim);
        ev.go      = frm_pulse;
        ev.restart = host_acc;
        ev.last    = at_end;
        ev.slot    = at_end ? lim : cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (frm_pulse) begin
            slot_q <= at_end ? '0 : cur + 1'b1;
        end else if (host_acc) begin
            slot_q <= '0;
        end
    end

endmodule

// File: rtl/dch_rx_pack.sv
module dch_rx_pack
    import dch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  frame_ev_t            ev,
    input  rate_e                rate,
    input  logic [1:0]           rx_pair,
    output logic [BYTE_BITS-1:0] rx_byte
);

    logic [BYTE_BITS-1:0] acc_q;
    logic [BYTE_BITS-1:0] base;
    logic [BYTE_BITS-1:0] nxt;

    always_comb begin
        base = ev.restart ? '0 : acc_q;
        if (rate == RATE_SINGLE)
            nxt = {base[BYTE_BITS-2:0], rx_pair[1]};
        else
            nxt = {base[BYTE_BITS-3:0], rx_pair};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            rx_byte <= '1;
        end else if (ev.go) begin
            if (ev.last) begin
                acc_q   <= '0;
                rx_byte <= nxt;
            end else begin
                acc_q <= nxt;
            end
        end else if (ev.restart) begin
            acc_q <= '0;
        end
    end

endmodule

// File: rtl/dch_tx_slice.sv
module dch_tx_slice
    import dch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  frame_ev_t            ev,
    input  rate_e                rate,
    input  logic                 wr_strobe,
    input  logic [BYTE_BITS-1:0] wr_byte,
    output logic [1:0]           tx_pair
);

    logic [BYTE_BITS-1:0] hold_q;
    logic [BYTE_BITS-1:0] src;
    logic [BYTE_BITS-1:0] moved;
    logic [1:0]           pick;

    always_comb begin
        src = wr_strobe ? wr_byte : hold_q;
        if (rate == RATE_SINGLE) begin
            moved = src << ev.slot;
            pick  = {moved[BYTE_BITS-1], 1'b1};
        end else begin
            moved = src << {ev.slot, 1'b0};
            pick  = moved[BYTE_BITS-1 -: 2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '1;
            tx_pair <= 2'b11;
        end else begin
            if (wr_strobe)
                hold_q <= wr_byte;
            if (ev.go)
                tx_pair <= pick;
        end
    end

endmodule

// File: rtl/dch_assembler.sv
module dch_assembler
    import dch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_pulse,
    input  logic       rate_low,
    input  logic [1:0] rx_pair,
    input  logic       rd_strobe,
    input  logic       wr_strobe,
    input  logic [7:0] wr_byte,
    output logic [1:0] tx_pair,
    output logic [7:0] rx_byte
);

    rate_e             rate;
    frame_ev_t         ev;
    logic [SLOT_W-1:0] slot_q;
    logic              host_acc;

    assign rate     = rate_e'(rate_low);
    assign host_acc = rd_strobe | wr_strobe;

    dch_slot_ctr u_slot (
        .clk       (clk),
        .rst       (rst),
        .frm_pulse (frm_pulse),
        .host_acc  (host_acc),
        .rate      (rate),
        .ev        (ev),
        .slot_q    (slot_q)
    );

    dch_rx_pack u_rx (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rate    (rate),
        .rx_pair (rx_pair),
        .rx_byte (rx_byte)
    );

    dch_tx_slice u_tx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rate      (rate),
        .wr_strobe (wr_strobe),
        .wr_byte   (wr_byte),
        .tx_pair   (tx_pair)
    );

endmodule

// File: rtl/dch_chk.sv
module dch_chk
    import dch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_pulse,
    input logic              rate_low,
    input logic              rd_strobe,
    input logic              wr_strobe,
    input logic [1:0]        tx_pair,
    input logic [7:0]        rx_byte,
    input logic [SLOT_W-1:0] slot_q
);

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (tx_pair == 2'b11 && rx_byte == 8'hFF));

    assert_rx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !frm_pulse |=> $stable(rx_byte));

    assert_idle_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_pulse && rate_low) |=> tx_pair[0]);

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        ((rd_strobe || wr_strobe) && !frm_pulse) |=> (slot_q == '0));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (frm_pulse && !rate_low && !rd_strobe && !wr_strobe && slot_q >= SLOT_W'(PAIR_SLOTS - 1))
        |=> (slot_q == '0));

    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !frm_pulse |=> $stable(tx_pair));

endmodule

bind dch_assembler dch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_pulse (frm_pulse),
    .rate_low  (rate_low),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .tx_pair   (tx_pair),
    .rx_byte   (rx_byte),
    .slot_q    (slot_q)
);

// File: tb/test_dch_assembler.sv
module test_dch_assembler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm_pulse = 1'b0;
    logic       rate_low = 1'b0;
    logic [1:0] rx_pair = 2'b00;
    logic       rd_strobe = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [1:0] tx_pair;
    logic [7:0] rx_byte;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state built from the requirements
    int         m_slot = 0;
    logic [7:0] m_acc  = 8'h00;
    logic [7:0] m_hold = 8'hFF;
    logic [7:0] e_rx   = 8'hFF;
    logic [1:0] e_tx   = 2'b11;

    always #2 clk = ~clk;

    dch_assembler i_dch_assembler (
        .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .rate_low(rate_low),
        .rx_pair(rx_pair), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .wr_byte(wr_byte), .tx_pair(tx_pair), .rx_byte(rx_byte)
    );

    function automatic logic [1:0] slice_of(input logic [7:0] b, input int k, input logic low);
        if (low) return {b[7-k], 1'b1};
        return {b[7-2*k], b[6-2*k]};
    endfunction

    function automatic logic [7:0] shift_in(input logic [7:0] a, input logic [1:0] p, input logic low);
        if (low) return {a[6:0], p[1]};
        return {a[5:0], p};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply one cycle of stimulus, advance the model, then compare
    task automatic step(input logic fp, input logic [1:0] pr, input logic rd,
                        input logic wr, input logic [7:0] wb, input string tag);
        int cur; int lim; int us; bit acc; bit lst; logic [7:0] src;
        frm_pulse = fp; rx_pair = pr; rd_strobe = rd; wr_strobe = wr; wr_byte = wb;
        acc = rd | wr;
        cur = acc ? 0 : m_slot;
        lim = rate_low ? 7 : 3;
        lst = (cur >= lim);
        us  = lst ? lim : cur;
        src = wr ? wb : m_hold;
        if (wr) m_hold = wb;
        if (fp) begin
            logic [7:0] nw;
            nw = shift_in(acc ? 8'h00 : m_acc, pr, rate_low);
            if (lst) begin e_rx = nw; m_acc = 8'h00; m_slot = 0; end
            else begin m_acc = nw; m_slot = cur + 1; end
            e_tx = slice_of(src, us, rate_low);
        end else if (acc) begin
            m_acc = 8'h00; m_slot = 0;
        end
        @(posedge clk);
        @(negedge clk);
        frm_pulse = 1'b0; rd_strobe = 1'b0; wr_strobe = 1'b0;
        if (fp) begin
            check({tag, " rx_byte"}, rx_byte, e_rx);
            check({tag, " tx_pair"}, {6'b0, tx_pair}, {6'b0, e_tx});
        end else begin
            check({tag, " R4 rx_byte hold"}, rx_byte, e_rx);
            check({tag, " R10 tx_pair hold"}, {6'b0, tx_pair}, {6'b0, e_tx});
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rx_byte reset", rx_byte, 8'hFF);
        check("R1 tx_pair reset", {6'b0, tx_pair}, 8'h03);
        rst = 1'b0;
        step(0, 2'b00, 0, 0, 8'h00, "R1");
        check("R1 rx_byte after release", rx_byte, 8'hFF);

        // R2 / R5 directed: write A5 then four frames of pairs 10,01,11,00
        rate_low = 1'b0;
        step(0, 2'b00, 0, 1, 8'hA5, "R5");
        step(1, 2'b10, 0, 0, 8'h00, "R2 R5 slot0");
        step(0, 2'b00, 0, 0, 8'h00, "R2");
        step(1, 2'b01, 0, 0, 8'h00, "R2 R5 slot1");
        step(1, 2'b11, 0, 0, 8'h00, "R2 R5 slot2");
        step(1, 2'b00, 0, 0, 8'h00, "R2 R5 slot3");
        check("R2 direct byte", rx_byte, 8'h9C);
        // R7: resend the same byte
        for (int i = 0; i < 4; i++) step(1, 2'b11, 0, 0, 8'h00, "R7 resend");
        check("R7 last slice", {6'b0, tx_pair}, 8'h01);

        // R3 / R6 directed: low rate
        rate_low = 1'b1;
        step(0, 2'b00, 1, 0, 8'h00, "R8 realign");
        step(0, 2'b00, 0, 1, 8'h3C, "R6");
        for (int i = 0; i < 8; i++)
            step(1, {((8'hB2 >> (7 - i)) & 8'h1) != 0, 1'b0}, 0, 0, 8'h00, "R3 R6 low rate");
        check("R3 direct byte", rx_byte, 8'hB2);

        // R8: partial byte discarded on read, write coinciding with pulse
        rate_low = 1'b0;
        step(1, 2'b11, 1, 0, 8'h00, "R8 read on pulse");
        step(1, 2'b11, 0, 0, 8'h00, "R8");
        step(1, 2'b01, 0, 1, 8'h4E, "R8 write on pulse");
        check("R8 new byte first slice", {6'b0, tx_pair}, 8'h01);
        for (int i = 0; i < 3; i++) step(1, 2'b10, 0, 0, 8'h00, "R8 after write");
        check("R8 realigned byte", rx_byte, 8'h6A);

        // R9: switch to high rate at slot 5 of low rate
        rate_low = 1'b1;
        step(0, 2'b00, 1, 0, 8'h00, "R9 realign");
        for (int i = 0; i < 5; i++) step(1, 2'b10, 0, 0, 8'h00, "R9 low frames");
        rate_low = 1'b0;
        step(1, 2'b01, 0, 0, 8'h00, "R9 wrap");
        for (int i = 0; i < 4; i++) step(1, 2'b10, 0, 0, 8'h00, "R9 after wrap");
        check("R9 byte after wrap", rx_byte, 8'hAA);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic fp; logic rd; logic wr;
            if ($urandom_range(0, 199) == 0) rate_low = ~rate_low;
            fp = ($urandom_range(0, 2) == 0);
            rd = ($urandom_range(0, 39) == 0);
            wr = ($urandom_range(0, 39) == 0);
            step(fp, 2'($urandom), rd, wr, 8'($urandom), "R2 R3 R5 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule